// File: doc/BRIEF.md
# Video Standard Auto Detector

This block watches a 10-bit parallel digital video stream and works out which of six standards it carries. Component and composite signals are told apart by the shape of their timing reference sequences. The line period tells 13.5 MHz component from 18 MHz component. The line count per frame tells a 525-line system from a 625-line one. The detector feeds a three-bit standard code and a valid flag to the downstream timing and checking logic. The detection logic runs continuously, one word per clock.

Two independent persistence filters keep a short disturbance from changing the reported standard. A new line class (signal type and sampling rate) must be seen on a parameterised number of consecutive lines before it is adopted. A new frame class must be seen on a parameterised number of consecutive frames. A manual override input replaces the reported code whenever it is enabled. Detection carries on underneath the override, so the detected code is current again as soon as the override is released.

Top module: `video_std_detect`

## Requirements
- R1: After reset, with the override off, stdCode is 3'b000 and stdValid is 0.
- R2: A component line marker is the word run 3FF, 000, 000 followed by an XYZ word with bit 9 set and not equal to 3FF. Only XYZ words with bit 6 set (end of active video) count as line markers. Words with bit 6 clear are ignored for line timing. A line seen this way reports stdCode bit 1 = 0.
- R3: A composite line marker is the word run 3FF, 000, 000, 000 followed by an ID word, and it counts as one line. The composite class reports stdCode bit 1 = 1 and bit 0 = 0.
- R4: For component lines, if the distance in words between consecutive line markers is at or above RATE_THRESH, the line is 18 MHz (stdCode bit 0 = 1). A smaller distance is 13.5 MHz (bit 0 = 0).
- R5: The field bit is bit 8 of the XYZ or ID word. A frame starts at a line marker whose field bit is 0 when the previous marker's field bit was 1. A frame of NTSC_LINES markers reports stdCode bit 2 = 0, and a frame of PAL_LINES markers reports bit 2 = 1.
- R6: The line class (stdCode bits 1:0) changes only after LINE_PERSIST consecutive line observations of the same new class. A shorter run followed by an agreeing line leaves it unchanged.
- R7: The frame class (stdCode bit 2) changes only after FRAME_PERSIST consecutive frames with the same new count. A frame whose count is neither NTSC_LINES nor PAL_LINES restarts the run from zero.
- R8: With the override off, stdValid is 1 exactly when both the line class and the frame class have been adopted at least once since reset.
- R9: While ovrEn is 1, stdCode equals ovrStd and stdValid is 1 in the same cycle. Detection continues meanwhile, and the detected code returns once ovrEn falls.
- R10: The detected code never reports composite together with 18 MHz.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Word clock |
| rstN | input | 1 | Synchronous reset, active low |
| dataIn | input | 10 | Parallel video word |
| ovrEn | input | 1 | Manual override enable |
| ovrStd | input | 3 | Standard code forced while ovrEn is 1 |
| stdCode | output | 3 | Bit 2 PAL(1)/NTSC(0), bit 1 composite(1)/component(0), bit 0 18 MHz(1)/13.5 MHz(0) |
| stdValid | output | 1 | Detected standard is settled, or the override is active |

## Verification
The marker word is captured at one rising edge. The datapath strobe registers there, and the control state registers on the next edge, so a detected change shows on stdCode two rising edges after the deciding XYZ or ID word. The override path is combinational and is due in the cycle where ovrEn is applied. Inputs change only on falling edges. After each stimulus stretch the bench drives three more filler words, then samples at a falling edge, which is later than every due point. Override results are sampled at the falling edge that follows the one where ovrEn and ovrStd were driven.

// File: rtl/vsd_pkg.sv
package vsd_pkg;
  localparam int DATA_W    = 10;
  localparam int FIELD_BIT = 8;
  localparam int HBIT      = 6;

  localparam int CODE_PAL       = 2;
  localparam int CODE_COMPOSITE = 1;
  localparam int CODE_FAST      = 0;

  // strobes and observations from datapath to control
  typedef struct packed {
    logic lineStb;
    logic frameStb;
    logic isComposite;
    logic isFast;
    logic linesOk;
    logic isPal;
  } obs_t;
endpackage

// File: rtl/vsd_datapath.sv
module vsd_datapath
  import vsd_pkg::*;
#(
  parameter int RATE_THRESH = 2000,
  parameter int NTSC_LINES  = 525,
  parameter int PAL_LINES   = 625
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] dataIn,
  output obs_t              obs
);
  localparam int MAX_LINES = (PAL_LINES > NTSC_LINES) ? PAL_LINES : NTSC_LINES;
  localparam int WCNT_W    = $clog2(RATE_THRESH + 1) + 1;
  localparam int LCNT_W    = $clog2(MAX_LINES + 2) + 1;
  localparam logic [WCNT_W-1:0] WCNT_MAX = '1;
  localparam logic [LCNT_W-1:0] LCNT_MAX = '1;
  localparam logic [DATA_W-1:0] ONES     = '1;
  localparam int HIST_D = 3;

  logic [DATA_W-1:0] hist [HIST_D];
  logic              idNext;
  logic [WCNT_W-1:0] wordCnt;
  logic [LCNT_W-1:0] lineCnt;
  logic              havePrevLine, havePrevField, prevField, haveFrame;

  logic trsHead, compEvt, lineEvt, evtField, frameStart;

  always_comb begin
    trsHead    = (hist[2] == ONES) && (hist[1] == '0) && (hist[0] == '0);
    compEvt    = trsHead && dataIn[DATA_W-1] && (dataIn != ONES) && dataIn[HBIT];
    lineEvt    = compEvt || idNext;
    evtField   = dataIn[FIELD_BIT];
    frameStart = havePrevField && prevField && !evtField;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < HIST_D; i++) hist[i] <= '0;
      idNext        <= 1'b0;
      wordCnt       <= '0;
      lineCnt       <= '0;
      havePrevLine  <= 1'b0;
      havePrevField <= 1'b0;
      prevField     <= 1'b0;
      haveFrame     <= 1'b0;
      obs           <= '0;
    end else begin
      hist[0] <= dataIn;
      for (int i = 1; i < HIST_D; i++) hist[i] <= hist[i-1];
      idNext <= trsHead && (dataIn == '0);
      wordCnt <= lineEvt ? WCNT_W'(1) : ((wordCnt == WCNT_MAX) ? WCNT_MAX : wordCnt + 1'b1);
      obs <= '0;
      if (lineEvt) begin
        havePrevLine      <= 1'b1;
        havePrevField     <= 1'b1;
        prevField         <= evtField;
        obs.lineStb       <= havePrevLine;
        obs.isComposite   <= idNext;
        obs.isFast        <= !idNext && (wordCnt >= WCNT_W'(RATE_THRESH));
        if (frameStart) begin
          haveFrame    <= 1'b1;
          lineCnt      <= LCNT_W'(1);
          obs.frameStb <= haveFrame;
          obs.linesOk  <= (lineCnt == LCNT_W'(NTSC_LINES)) || (lineCnt == LCNT_W'(PAL_LINES));
          obs.isPal    <= (lineCnt == LCNT_W'(PAL_LINES));
        end else begin
          lineCnt <= (lineCnt == LCNT_MAX) ? LCNT_MAX : lineCnt + 1'b1;
        end
      end
    end
  end

  // R2 R3: a line strobe only follows a header of zero words
  p_strobe_after_trs_r2: assert property (@(posedge clk) disable iff (!rstN)
    obs.lineStb |-> (hist[1] == '0) && (hist[2] == '0));

  // R5: a frame strobe never comes without a line strobe
  p_frame_on_line_r5: assert property (@(posedge clk) disable iff (!rstN)
    obs.frameStb |-> obs.lineStb);
endmodule

// File: rtl/vsd_control.sv
module vsd_control
  import vsd_pkg::*;
#(
  parameter int LINE_PERSIST  = 8,
  parameter int FRAME_PERSIST = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  obs_t       obs,
  output logic [1:0] repLine,
  output logic       repPal,
  output logic       locked
);
  localparam int LRUN_W = $clog2(LINE_PERSIST + 1);
  localparam int FRUN_W = $clog2(FRAME_PERSIST + 1);

  logic [1:0]        candLine;
  logic [LRUN_W-1:0] lineRun;
  logic              lineLocked;
  logic              candPal;
  logic [FRUN_W-1:0] frameRun;
  logic              frameLocked;
  logic [1:0]        lineObs;

  always_comb lineObs = {obs.isComposite, obs.isFast};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      repLine <= '0; candLine <= '0; lineRun <= '0; lineLocked <= 1'b0;
      repPal <= 1'b0; candPal <= 1'b0; frameRun <= '0; frameLocked <= 1'b0;
    end else begin
      if (obs.lineStb) begin
        if (lineLocked && lineObs == repLine) begin
          lineRun <= '0;
        end else if (lineRun != '0 && lineObs == candLine) begin
          if (lineRun == LRUN_W'(LINE_PERSIST - 1)) begin
            repLine    <= lineObs;
            lineLocked <= 1'b1;
            lineRun    <= '0;
          end else begin
            lineRun <= lineRun + 1'b1;
          end
        end else begin
          candLine <= lineObs;
          lineRun  <= LRUN_W'(1);
        end
      end
      if (obs.frameStb) begin
        if (!obs.linesOk) begin
          frameRun <= '0;
        end else if (frameLocked && obs.isPal == repPal) begin
          frameRun <= '0;
        end else if (frameRun != '0 && obs.isPal == candPal) begin
          if (frameRun == FRUN_W'(FRAME_PERSIST - 1)) begin
            repPal      <= obs.isPal;
            frameLocked <= 1'b1;
            frameRun    <= '0;
          end else begin
            frameRun <= frameRun + 1'b1;
          end
        end else begin
          candPal  <= obs.isPal;
          frameRun <= FRUN_W'(1);
        end
      end
    end
  end

  always_comb locked = lineLocked && frameLocked;

  p_line_run_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    lineRun < LRUN_W'(LINE_PERSIST));

  p_line_change_strobe_r6: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(repLine) |-> $past(obs.lineStb));

  p_frame_change_strobe_r7: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(repPal) |-> $past(obs.frameStb && obs.linesOk));

  p_lock_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    $past(locked) |-> locked);
endmodule

// File: rtl/video_std_detect.sv
module video_std_detect #(
  parameter int RATE_THRESH   = 2000,
  parameter int NTSC_LINES    = 525,
  parameter int PAL_LINES     = 625,
  parameter int LINE_PERSIST  = 8,
  parameter int FRAME_PERSIST = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [vsd_pkg::DATA_W-1:0] dataIn,
  input  logic                       ovrEn,
  input  logic [2:0]                 ovrStd,
  output logic [2:0]                 stdCode,
  output logic                       stdValid
);
  vsd_pkg::obs_t obs;
  logic [1:0]    repLine;
  logic          repPal;
  logic          locked;

  vsd_datapath #(
    .RATE_THRESH(RATE_THRESH),
    .NTSC_LINES (NTSC_LINES),
    .PAL_LINES  (PAL_LINES)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .dataIn(dataIn),
    .obs   (obs)
  );

  vsd_control #(
    .LINE_PERSIST (LINE_PERSIST),
    .FRAME_PERSIST(FRAME_PERSIST)
  ) u_ctl (
    .clk    (clk),
    .rstN   (rstN),
    .obs    (obs),
    .repLine(repLine),
    .repPal (repPal),
    .locked (locked)
  );

  always_comb begin
    stdCode  = ovrEn ? ovrStd : {repPal, repLine};
    stdValid = ovrEn || locked;
  end

  p_composite_slow_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!ovrEn && stdCode[vsd_pkg::CODE_COMPOSITE]) |-> !stdCode[vsd_pkg::CODE_FAST]);
endmodule

// File: tb/video_std_detect_tb.sv
module video_std_detect_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [9:0] dataIn = '0;
  logic       ovrEn = 1'b0;
  logic [2:0] ovrStd = '0;
  logic [2:0] stdCode;
  logic       stdValid;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam int NL = 21;
  localparam int PL = 25;

  always #2 clk = ~clk;

  video_std_detect #(
    .RATE_THRESH(40), .NTSC_LINES(NL), .PAL_LINES(PL),
    .LINE_PERSIST(8), .FRAME_PERSIST(4)
  ) u_dut (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .ovrEn(ovrEn),
    .ovrStd(ovrStd), .stdCode(stdCode), .stdValid(stdValid)
  );

  function automatic logic [2:0] expCode(bit pal, bit comp, bit fast);
    return {pal, comp, comp ? 1'b0 : fast};
  endfunction

  function automatic logic [9:0] filler();
    return 10'(($urandom % 1016) + 4);
  endfunction

  task automatic chk(string tag, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put(logic [9:0] w);
    @(negedge clk);
    dataIn = w;
  endtask

  task automatic send_line(bit comp, bit fast, bit fld);
    int len = fast ? 40 + int'($urandom % 17) : 20 + int'($urandom % 12);
    if (!comp) begin
      put(10'h3FF); put(10'h000); put(10'h000);
      put(10'h240 | (10'(fld) << 8) | 10'($urandom % 64));
      for (int i = 0; i < 4; i++) put(filler());
      put(10'h3FF); put(10'h000); put(10'h000);
      put(10'h200 | (10'(fld) << 8) | 10'($urandom % 64));
      for (int i = 0; i < len - 12; i++) put(filler());
    end else begin
      put(10'h3FF); put(10'h000); put(10'h000); put(10'h000);
      put((10'(fld) << 8) | 10'(1 + $urandom % 254));
      for (int i = 0; i < len - 5; i++) put(filler());
    end
  endtask

  task automatic send_lines(bit comp, bit fast, int n, bit fld);
    for (int i = 0; i < n; i++) send_line(comp, fast, fld);
  endtask

  task automatic send_frame(bit comp, bit fast, int total);
    send_lines(comp, fast, total / 2, 1'b0);
    send_lines(comp, fast, total - total / 2, 1'b1);
  endtask

  task automatic settle();
    for (int i = 0; i < 3; i++) put(filler());
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    chk("R1 code in reset", {1'b0, stdCode}, 4'h0);
    rstN = 1'b1;
    put(filler());
    chk("R1 code after reset", {1'b0, stdCode}, 4'h0);
    chk("R1 valid after reset", {3'b0, stdValid}, 4'h0);

    // component 18 MHz 625-line: line class locks first, frame class later
    send_frame(1'b0, 1'b1, PL);
    send_frame(1'b0, 1'b1, PL);
    settle();
    chk("R8 valid before frame lock", {3'b0, stdValid}, 4'h0);
    chk("R2 R4 line class fast component", {2'b0, stdCode[1:0]}, {2'b0, expCode(1'b0, 1'b0, 1'b1)[1:0]});
    for (int f = 0; f < 4; f++) send_frame(1'b0, 1'b1, PL);
    settle();
    chk("R5 R7 component fast PAL", {1'b0, stdCode}, {1'b0, expCode(1'b1, 1'b0, 1'b1)});
    chk("R8 valid after both locks", {3'b0, stdValid}, 4'h1);

    // seven slow lines inside a frame do not switch the line class
    send_lines(1'b0, 1'b1, 9, 1'b0);
    send_lines(1'b0, 1'b0, 7, 1'b0);
    send_lines(1'b0, 1'b1, 9, 1'b1);
    settle();
    chk("R6 seven-line burst ignored", {1'b0, stdCode}, {1'b0, expCode(1'b1, 1'b0, 1'b1)});

    // eight slow lines switch to 13.5 MHz
    send_lines(1'b0, 1'b1, 5, 1'b0);
    send_lines(1'b0, 1'b0, 8, 1'b0);
    send_lines(1'b0, 1'b0, 12, 1'b1);
    settle();
    chk("R6 eight-line run adopted", {1'b0, stdCode}, {1'b0, expCode(1'b1, 1'b0, 1'b0)});

    // 525-line frames with a bad frame in the run
    send_frame(1'b0, 1'b0, NL);
    send_frame(1'b0, 1'b0, NL);
    send_frame(1'b0, 1'b0, NL + 2);
    for (int f = 0; f < 4; f++) send_frame(1'b0, 1'b0, NL);
    settle();
    chk("R7 bad count restarts run", {1'b0, stdCode}, {1'b0, expCode(1'b1, 1'b0, 1'b0)});
    send_frame(1'b0, 1'b0, NL);
    settle();
    chk("R5 R7 component slow NTSC", {1'b0, stdCode}, {1'b0, expCode(1'b0, 1'b0, 1'b0)});

    // composite, 525 lines, long lines must not read as fast
    send_frame(1'b1, 1'b1, NL);
    send_frame(1'b1, 1'b1, NL);
    settle();
    chk("R3 R10 composite NTSC", {1'b0, stdCode}, {1'b0, expCode(1'b0, 1'b1, 1'b0)});

    // composite 625 lines
    for (int f = 0; f < 4; f++) send_frame(1'b1, 1'b0, PL);
    settle();
    chk("R7 composite three frames held", {1'b0, stdCode}, {1'b0, expCode(1'b0, 1'b1, 1'b0)});
    send_frame(1'b1, 1'b0, PL);
    settle();
    chk("R3 R5 composite PAL", {1'b0, stdCode}, {1'b0, expCode(1'b1, 1'b1, 1'b0)});

    // override with random codes
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      ovrEn  = 1'b1;
      ovrStd = 3'($urandom % 8);
      dataIn = filler();
      put(filler());
      chk("R9 override code", {1'b0, stdCode}, {1'b0, ovrStd});
      chk("R9 override valid", {3'b0, stdValid}, 4'h1);
    end
    send_frame(1'b1, 1'b0, PL);
    @(negedge clk);
    ovrEn = 1'b0;
    dataIn = filler();
    put(filler());
    chk("R9 detected code returns", {1'b0, stdCode}, {1'b0, expCode(1'b1, 1'b1, 1'b0)});
    chk("R9 R8 valid after release", {3'b0, stdValid}, 4'h1);

    finish_run();
  end
endmodule